// File: doc/BRIEF.md
# TDMA Injection Gate for a Network Interface

The gate sits between the transmit queues of a packet-switched network interface and the single link into the network. Guaranteed bandwidth is enforced here, where flits are injected, because the routers hold no slot tables. A slot table with one entry per slot records either a connection ID or "free". A slot counter steps through the entries and wraps after `SLOTS` entries. The design is meant for slot counts of 5, 8, 16 or 32. A connection's share of the link is the number of entries it holds in one rotation.

A slot is one transfer opportunity on the link. When a slot opens, the gate chooses one source. The owning guaranteed connection goes first if it has a flit ready. Otherwise the best-effort queue may use the slot. A guaranteed connection never sends in a slot owned by another connection, even when that slot would otherwise go unused. The chosen flit is registered and held on the link until the downstream side accepts it, and the slot ends at that point. Slot table entries are written through a plain address/data/write-enable port.

The controller has two states. In `ST_PICK` the gate reads the entry for the current slot and makes its choice. If nothing is eligible, the slot is closed at once and the gate stays in `ST_PICK` (transition *skip*). If a flit is taken, the gate moves to `ST_SEND` (transition *take*). `ST_SEND` holds the flit until `out_ready` is high, then closes the slot and returns to `ST_PICK` (transition *accept*). While `out_ready` stays low the gate remains in `ST_SEND` (transition *stall*).

Top module: `tdma_inject_gate`

## Requirements
- R1: During reset and until the first flit is taken, `out_valid` is 0, the slot counter is 0 and every table entry is free. The first flit taken after reset carries `out_slot` = 0.
- R2: The slot counter moves forward by one at the close of every slot and wraps from `SLOTS`-1 to 0. A slot closes when its flit is accepted, or in the cycle it opens if nothing is taken. With traffic in every slot, consecutive flits carry consecutive `out_slot` values modulo `SLOTS`.
- R3: At most one flit is taken per slot. At most one of `gt_ready`/`be_ready` is high at a time, and all of them are low while a flit is held on the output.
- R4: A flit from guaranteed connection c leaves only in a slot whose entry has the owned bit set and ID equal to c. A connection that owns no entry never sends.
- R5: In a slot owned by connection c, c's flit is taken whenever `gt_valid[c]` is high, ahead of best-effort traffic. Over whole rotations, a connection that always has flits sends exactly one flit per owned entry per rotation.
- R6: In a free slot the best-effort flit is taken if `be_valid` is high. If no source is eligible, no flit is presented and all ready outputs stay low.
- R7: In a slot owned by a connection that has no flit ready, the best-effort queue may send. No other guaranteed connection may send in that slot.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_is_gt`, `out_conn` and `out_slot` hold their values and the slot counter does not move.
- R9: Flits leave in the order each source offered them, with data unchanged. `out_is_gt` is 1 with `out_conn` = connection ID for guaranteed flits, and `out_is_gt` is 0 with `out_conn` = 0 for best-effort flits.
- R10: A write with `tbl_we` = 1 sets entry `tbl_slot` to {`tbl_own`, `tbl_id`} at the clock edge. The new entry applies to every slot opened after that edge. Writes with `tbl_slot` >= `SLOTS` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gt_valid | input | NUM_CONN | Flit present, one bit per guaranteed connection |
| gt_data | input | NUM_CONN*FLIT_W | Flit of connection c at bits [c*FLIT_W +: FLIT_W] |
| gt_ready | output | NUM_CONN | Flit taken from connection c |
| be_valid | input | 1 | Best-effort flit present |
| be_data | input | FLIT_W | Best-effort flit |
| be_ready | output | 1 | Best-effort flit taken |
| out_valid | output | 1 | Flit presented on the link |
| out_data | output | FLIT_W | Presented flit |
| out_is_gt | output | 1 | 1 for a guaranteed flit, 0 for best effort |
| out_conn | output | ID_W | Connection ID of a guaranteed flit, else 0 |
| out_slot | output | SLOT_W | Slot in which the flit was taken |
| out_ready | input | 1 | Link accepts the presented flit |
| tbl_we | input | 1 | Slot table write enable |
| tbl_slot | input | SLOT_W | Entry to write |
| tbl_own | input | 1 | 1 = entry owned, 0 = free |
| tbl_id | input | ID_W | Owning connection ID |

## Verification
A corrupted slot counter shows up on the next flit as an `out_slot` value that breaks the modulo-`SLOTS` sequence, or as a guaranteed flit sitting in a slot its connection does not own. A stale or wrongly written table entry shows within one rotation as a wrong per-connection flit count or a best-effort flit in a slot whose owner had data. A state register stuck in `ST_SEND` or `ST_PICK` shows within a cycle or two as an output that changes during a stall, a ready pulse while a flit is held, or a gap in a source's sequence numbers.

// File: rtl/tdma_gate_pkg.sv
package tdma_gate_pkg;

    typedef enum logic {
        ST_PICK = 1'b0,
        ST_SEND = 1'b1
    } gate_state_e;

    typedef enum logic [1:0] {
        GR_NONE = 2'd0,
        GR_GT   = 2'd1,
        GR_BE   = 2'd2
    } grant_e;

endpackage

// File: rtl/tdma_slot_counter.sv
module tdma_slot_counter #(
    parameter  int SLOTS  = 5,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (adv) begin
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
        end
    end

    assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST);

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && slot == LAST) |=> slot == '0);

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && slot != LAST) |=> slot == SLOT_W'($past(slot) + 1'b1));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(slot));

endmodule

// File: rtl/tdma_slot_table.sv
module tdma_slot_table #(
    parameter  int SLOTS  = 5,
    parameter  int ID_W   = 2,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] waddr,
    input  logic              wown,
    input  logic [ID_W-1:0]   wid,
    input  logic [SLOT_W-1:0] raddr,
    output logic              rown,
    output logic [ID_W-1:0]   rid
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [SLOTS-1:0]           own_q;
    logic [SLOTS-1:0][ID_W-1:0] id_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= '0;
            id_q  <= '0;
        end else if (we) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (waddr == SLOT_W'(i)) begin
                    own_q[i] <= wown;
                    id_q[i]  <= wid;
                end
            end
        end
    end

    assign rown = own_q[raddr];
    assign rid  = id_q[raddr];

    assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr <= LAST) |=>
            (own_q[$past(waddr)] == $past(wown)) && (id_q[$past(waddr)] == $past(wid)));

    assert_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr > LAST) |=> $stable(own_q) && $stable(id_q));

endmodule

// File: rtl/tdma_inject_pick.sv
module tdma_inject_pick
    import tdma_gate_pkg::*;
#(
    parameter int NUM_CONN = 4,
    parameter int ID_W     = 2
) (
    input  logic                own,
    input  logic [ID_W-1:0]     id,
    input  logic [NUM_CONN-1:0] gt_valid,
    input  logic                be_valid,
    output grant_e              kind,
    output logic [NUM_CONN-1:0] gt_sel
);

    logic [NUM_CONN-1:0] owner_hit;

    for (genvar c = 0; c < NUM_CONN; c++) begin : g_conn
        assign owner_hit[c] = own && (id == ID_W'(c)) && gt_valid[c];
    end

    always_comb begin
        if (|owner_hit) begin
            kind = GR_GT;
        end else if (be_valid) begin
            kind = GR_BE;
        end else begin
            kind = GR_NONE;
        end
    end

    assign gt_sel = owner_hit;

endmodule

// File: rtl/tdma_inject_gate.sv
module tdma_inject_gate
    import tdma_gate_pkg::*;
#(
    parameter  int NUM_CONN = 4,
    parameter  int SLOTS    = 5,
    parameter  int FLIT_W   = 16,
    localparam int ID_W     = (NUM_CONN > 1) ? $clog2(NUM_CONN) : 1,
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CONN-1:0]        gt_valid,
    input  logic [NUM_CONN*FLIT_W-1:0] gt_data,
    output logic [NUM_CONN-1:0]        gt_ready,
    input  logic                       be_valid,
    input  logic [FLIT_W-1:0]          be_data,
    output logic                       be_ready,
    output logic                       out_valid,
    output logic [FLIT_W-1:0]          out_data,
    output logic                       out_is_gt,
    output logic [ID_W-1:0]            out_conn,
    output logic [SLOT_W-1:0]          out_slot,
    input  logic                       out_ready,
    input  logic                       tbl_we,
    input  logic [SLOT_W-1:0]          tbl_slot,
    input  logic                       tbl_own,
    input  logic [ID_W-1:0]            tbl_id
);

    gate_state_e         state_q, state_d;
    logic                slot_adv;
    logic [SLOT_W-1:0]   slot;
    logic                cur_own;
    logic [ID_W-1:0]     cur_id;
    grant_e              kind;
    logic [NUM_CONN-1:0] sel;
    logic [FLIT_W-1:0]   pick_data;

    tdma_slot_counter #(.SLOTS(SLOTS)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (slot_adv),
        .slot  (slot)
    );

    tdma_slot_table #(.SLOTS(SLOTS), .ID_W(ID_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_slot),
        .wown  (tbl_own),
        .wid   (tbl_id),
        .raddr (slot),
        .rown  (cur_own),
        .rid   (cur_id)
    );

    tdma_inject_pick #(.NUM_CONN(NUM_CONN), .ID_W(ID_W)) u_pick (
        .own      (cur_own),
        .id       (cur_id),
        .gt_valid (gt_valid),
        .be_valid (be_valid),
        .kind     (kind),
        .gt_sel   (sel)
    );

    // next state and slot close
    always_comb begin
        state_d  = state_q;
        slot_adv = 1'b0;
        unique case (state_q)
            ST_PICK: begin
                if (kind == GR_NONE) begin
                    slot_adv = 1'b1;
                end else begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (out_ready) begin
                    slot_adv = 1'b1;
                    state_d  = ST_PICK;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PICK;
        end else begin
            state_q <= state_d;
        end
    end

    assign gt_ready = (state_q == ST_PICK) ? sel : '0;
    assign be_ready = (state_q == ST_PICK) && (kind == GR_BE);

    always_comb begin
        pick_data = be_data;
        for (int c = 0; c < NUM_CONN; c++) begin
            if (sel[c]) begin
                pick_data = gt_data[c*FLIT_W +: FLIT_W];
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_is_gt <= 1'b0;
            out_conn  <= '0;
            out_slot  <= '0;
        end else begin
            unique case (state_q)
                ST_PICK: begin
                    if (kind != GR_NONE) begin
                        out_valid <= 1'b1;
                        out_data  <= pick_data;
                        out_is_gt <= (kind == GR_GT);
                        out_conn  <= (kind == GR_GT) ? cur_id : '0;
                        out_slot  <= slot;
                    end
                end
                ST_SEND: begin
                    if (out_ready) begin
                        out_valid <= 1'b0;
                    end
                end
            endcase
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            out_valid && $stable(out_data) && $stable(out_is_gt) &&
            $stable(out_conn) && $stable(out_slot));

    assert_slot_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(slot));

    assert_single_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gt_ready, be_ready}));

    assert_no_take_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (gt_ready == '0) && !be_ready);

    assert_owner_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|gt_ready) |-> cur_own && (gt_ready == (NUM_CONN'(1) << cur_id)));

    assert_owner_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && cur_own && ((gt_valid & (NUM_CONN'(1) << cur_id)) != '0))
            |-> !be_ready);

    assert_flit_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_slot == $past(slot));

endmodule

// File: tb/tdma_inject_gate_tb.sv
`timescale 1ns/1ps
module tdma_inject_gate_tb;

    localparam int NC = 4;
    localparam int NS = 5;
    localparam int FW = 16;
    localparam int IW = 2;
    localparam int SW = 3;
    localparam int LOGN = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NC-1:0]    gt_valid = '0;
    logic [NC*FW-1:0] gt_data;
    logic [NC-1:0]    gt_ready;
    logic             be_valid = 1'b0;
    logic [FW-1:0]    be_data;
    logic             be_ready;
    logic             out_valid;
    logic [FW-1:0]    out_data;
    logic             out_is_gt;
    logic [IW-1:0]    out_conn;
    logic [SW-1:0]    out_slot;
    logic             out_ready = 1'b1;
    logic             tbl_we = 1'b0;
    logic [SW-1:0]    tbl_slot = '0;
    logic             tbl_own = 1'b0;
    logic [IW-1:0]    tbl_id = '0;

    tdma_inject_gate #(.NUM_CONN(NC), .SLOTS(NS), .FLIT_W(FW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .gt_valid(gt_valid), .gt_data(gt_data), .gt_ready(gt_ready),
        .be_valid(be_valid), .be_data(be_data), .be_ready(be_ready),
        .out_valid(out_valid), .out_data(out_data), .out_is_gt(out_is_gt),
        .out_conn(out_conn), .out_slot(out_slot), .out_ready(out_ready),
        .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_own(tbl_own), .tbl_id(tbl_id)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // sources: tag in [15:12], sequence in [11:0]
    logic [11:0] src_seq [NC];
    logic [11:0] be_seq;
    always_comb begin
        for (int c = 0; c < NC; c++) gt_data[c*FW +: FW] = {4'(c), src_seq[c]};
        be_data = {4'hF, be_seq};
    end

    logic [SW-1:0] lg_slot [LOGN];
    logic          lg_gt   [LOGN];
    logic [IW-1:0] lg_conn [LOGN];
    logic [FW-1:0] lg_data [LOGN];
    int log_n = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) src_seq[c] <= '0;
            be_seq <= '0;
        end else begin
            for (int c = 0; c < NC; c++)
                if (gt_valid[c] && gt_ready[c]) src_seq[c] <= src_seq[c] + 1'b1;
            if (be_valid && be_ready) be_seq <= be_seq + 1'b1;
            if (out_valid && out_ready && log_n < LOGN) begin
                lg_slot[log_n] <= out_slot;
                lg_gt[log_n]   <= out_is_gt;
                lg_conn[log_n] <= out_conn;
                lg_data[log_n] <= out_data;
                log_n <= log_n + 1;
            end
        end
    end

    // bench model of the table and expected sequences
    bit         model_own [NS];
    int         model_id  [NS];
    logic [11:0] exp_seq  [NC];
    logic [11:0] exp_be;
    int cnt [NC];
    int be_owned;
    int rd_ptr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_log(input int target);
        while (log_n < target) @(negedge clk);
    endtask

    task automatic skip_log(input int upto);
        for (int k = rd_ptr; k < upto; k++) begin
            if (lg_gt[k]) exp_seq[lg_conn[k]] = lg_data[k][11:0] + 1'b1;
            else exp_be = lg_data[k][11:0] + 1'b1;
        end
        rd_ptr = upto;
    endtask

    task automatic check_log(input int n, input bit contiguous);
        int prev = -1;
        for (int c = 0; c < NC; c++) cnt[c] = 0;
        be_owned = 0;
        for (int k = rd_ptr; k < rd_ptr + n; k++) begin
            int s = int'(lg_slot[k]);
            int cn = int'(lg_conn[k]);
            if (contiguous && prev >= 0)
                chk(s == (prev + 1) % NS, "R2", "slot sequence", s, (prev + 1) % NS);
            if (lg_gt[k]) begin
                chk(model_own[s] && model_id[s] == cn, "R4", "guaranteed flit slot owner", cn, model_id[s]);
                chk(lg_data[k] == {4'(cn), exp_seq[cn]}, "R9", "guaranteed flit data",
                    int'(lg_data[k]), int'({4'(cn), exp_seq[cn]}));
                exp_seq[cn] = exp_seq[cn] + 1'b1;
                cnt[cn]++;
            end else begin
                chk(lg_data[k] == {4'hF, exp_be} && cn == 0, "R9", "best-effort flit data",
                    int'(lg_data[k]), int'({4'hF, exp_be}));
                exp_be = exp_be + 1'b1;
                if (model_own[s]) begin
                    be_owned++;
                    chk(!gt_valid[model_id[s]], "R5", "best effort took slot of ready owner", s, -1);
                end
            end
            prev = s;
        end
        rd_ptr = rd_ptr + n;
    endtask

    task automatic write_entry(input int slot, input bit own, input int id);
        @(negedge clk);
        tbl_we = 1'b1; tbl_slot = SW'(slot); tbl_own = own; tbl_id = IW'(id);
        @(negedge clk);
        tbl_we = 1'b0;
        if (slot < NS) begin
            model_own[slot] = own;
            model_id[slot] = id;
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        skip_log(log_n);
    endtask

    task automatic t_reset();
        for (int s = 0; s < NS; s++) begin model_own[s] = 1'b0; model_id[s] = 0; end
        for (int c = 0; c < NC; c++) exp_seq[c] = '0;
        exp_be = '0;
        be_valid = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        chk(out_valid == 1'b0, "R1", "out_valid at reset release", int'(out_valid), 0);
        wait_log(6);
        chk(lg_slot[0] == '0, "R1", "first flit slot", int'(lg_slot[0]), 0);
        check_log(6, 1'b1);
        chk(cnt[0] + cnt[1] + cnt[2] + cnt[3] == 0, "R6", "free slots carry best effort only",
            cnt[0] + cnt[1] + cnt[2] + cnt[3], 0);
    endtask

    task automatic t_reserved();
        write_entry(1, 1'b1, 0);
        write_entry(3, 1'b1, 2);
        gt_valid = 4'b1111;
        settle();
        wait_log(rd_ptr + 10);
        check_log(10, 1'b1);
        chk(cnt[0] == 2, "R5", "conn0 flits in two rotations", cnt[0], 2);
        chk(cnt[2] == 2, "R5", "conn2 flits in two rotations", cnt[2], 2);
        chk(cnt[1] == 0, "R4", "conn1 owns nothing", cnt[1], 0);
        chk(cnt[3] == 0, "R4", "conn3 owns nothing", cnt[3], 0);
    endtask

    task automatic t_owner_idle();
        gt_valid = 4'b1110;
        settle();
        wait_log(rd_ptr + 10);
        check_log(10, 1'b1);
        chk(cnt[0] == 0, "R7", "idle owner sends nothing", cnt[0], 0);
        chk(cnt[1] == 0, "R7", "other connection kept out of idle slot", cnt[1], 0);
        chk(be_owned == 2, "R7", "best effort fills idle owned slot", be_owned, 2);
        chk(cnt[2] == 2, "R5", "conn2 unaffected", cnt[2], 2);
    endtask

    task automatic t_backpressure();
        logic [FW-1:0] hd;
        logic [SW-1:0] hs;
        logic hg;
        logic [IW-1:0] hc;
        int held_idx;
        gt_valid = 4'b1111;
        settle();
        @(negedge clk);
        out_ready = 1'b0;
        while (!out_valid) @(negedge clk);
        held_idx = log_n;
        hd = out_data; hs = out_slot; hg = out_is_gt; hc = out_conn;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(out_valid && out_data == hd && out_slot == hs && out_is_gt == hg && out_conn == hc,
                "R8", "output held under stall", int'(out_data), int'(hd));
            chk(gt_ready == '0 && !be_ready, "R3", "no take while flit held",
                int'({gt_ready, be_ready}), 0);
        end
        out_ready = 1'b1;
        wait_log(held_idx + 3);
        chk(lg_data[held_idx] == hd, "R8", "held flit delivered", int'(lg_data[held_idx]), int'(hd));
        chk(int'(lg_slot[held_idx + 1]) == (int'(hs) + 1) % NS, "R8", "slot frozen during stall",
            int'(lg_slot[held_idx + 1]), (int'(hs) + 1) % NS);
        check_log(log_n - rd_ptr, 1'b1);
    endtask

    task automatic t_table_write();
        write_entry(5, 1'b1, 3);
        write_entry(7, 1'b1, 3);
        write_entry(4, 1'b1, 1);
        settle();
        wait_log(rd_ptr + 10);
        check_log(10, 1'b1);
        chk(cnt[1] == 2, "R10", "new owner of slot 4", cnt[1], 2);
        chk(cnt[3] == 0, "R10", "out-of-range writes ignored", cnt[3], 0);
        chk(cnt[0] == 2 && cnt[2] == 2, "R10", "other entries unchanged", cnt[0] + cnt[2], 4);
    endtask

    task automatic t_idle();
        gt_valid = '0;
        be_valid = 1'b0;
        settle();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!out_valid && gt_ready == '0 && !be_ready, "R6", "no flit without a source",
                int'({out_valid, gt_ready, be_ready}), 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_reserved();
        t_owner_idle();
        t_backpressure();
        t_table_write();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule